// File: doc/BRIEF.md
# Attribute-Driven Text Pixel Generator

This block turns one character cell of a text display into a stream of coloured dots. For each cell it is given the character code, the cell's attribute byte, the scanline inside the cell and a 2-bit group select taken from a global control latch. From these it forms a 15-bit address into a 32 KB glyph memory organised as sixteen 2 KB glyph sets. The byte that comes back is registered and shifted out one dot per clock, and each dot is coloured with the foreground or the background 3-bit RGB colour carried in the same attribute byte.

The glyph set used by a cell is chosen by four bits: the two group bits from the latch select a group of four sets, and attribute bits 7 and 3 pick one set inside that group. The cell counters upstream pulse `fetch_i` in the clock where the inputs for a new cell are valid; the glyph memory answers one clock later, and the first dot of the cell appears on the output in the clock after that. Pulsing `fetch_i` every eight clocks gives a gap-free dot stream.

The dot shifter is a two-state machine. `ST_IDLE` emits no dots; transition `LOAD_GLYPH` (a glyph arriving) moves it to `ST_SHIFT`. In `ST_SHIFT` transition `RELOAD` (a new glyph arriving, at any dot) stays in `ST_SHIFT` and restarts the cell, and transition `CELL_DONE` (eighth dot shown, no new glyph) returns to `ST_IDLE`.

Top module: `text_dot_gen`

## Requirements
- R1: In a clock with `fetch_i` high, `rom_addr_o` equals {group_i[1:0], attr_i[7], attr_i[3], code_i[7:0], row_i[2:0]} (bit 14 down to bit 0); for example group 00 with only attribute bit 3 set selects set 1, base address 0x0800.
- R2: After reset and whenever no cell is being shown, `dot_valid_o` is 0 and `dot_rgb_o` is 000 (black).
- R3: When `fetch_i` is high in clock t, the first dot of that cell is on the outputs in clock t+2.
- R4: A glyph bit of 1 gives `dot_rgb_o` = attr[6:4], a 0 gives attr[2:0]; in both fields and on the output the top bit is green, the middle red and the lowest blue.
- R5: The glyph byte is shown most significant bit first over eight consecutive clocks; with no further fetch, `dot_valid_o` then returns to 0.
- R6: Fetches exactly eight clocks apart produce a continuous stream with `dot_valid_o` held at 1.
- R7: Changes to `attr_i`, `code_i`, `row_i` and `group_i` in clocks where `fetch_i` is low do not alter the dots being shown.
- R8: Attribute 0x70 shows glyph 1 bits as white (111) and 0 bits as black (000), using the first set of the selected group.
- R9: A fetch issued before the current cell has shown all eight dots abandons the rest of that cell; the new cell's first dot appears two clocks after its fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_i | input | 1 | Cell inputs valid, start a glyph fetch |
| code_i | input | 8 | Character code |
| attr_i | input | 8 | Cell attribute byte (colours and set select bits) |
| row_i | input | 3 | Scanline inside the cell |
| group_i | input | 2 | Glyph set group from the control latch |
| rom_addr_o | output | 15 | Glyph memory address |
| rom_data_i | input | 8 | Glyph byte, one clock after the address |
| dot_valid_o | output | 1 | A dot of a cell is being shown |
| dot_rgb_o | output | 3 | Dot colour {green, red, blue} |

## Verification
The bench builds the block with its default parameters: an 8-bit code, 3 row bits, 2 group bits and an 8-dot glyph, which makes every one of the sixteen glyph sets and every colour pair reachable. The glyph memory is modelled with a computed pattern so each address returns a distinct byte, and scenarios cover back-to-back cells, cells with idle gaps between them, cells cut short by an early fetch, and directed attribute values for the white-on-black case and the slot-select corners.

// File: rtl/text_dot_pkg.sv
package text_dot_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shift_state_t;

    localparam int ATTR_W      = 8;
    localparam int ATTR_FG_LSB = 4;
    localparam int ATTR_BG_LSB = 0;
    localparam int ATTR_SEL_HI = 7;
    localparam int ATTR_SEL_LO = 3;

endpackage

// File: rtl/text_dot_addr.sv
module text_dot_addr #(
    parameter int CODE_W = 8,
    parameter int ROW_W  = 3,
    parameter int GRP_W  = 2,
    localparam int SET_W  = GRP_W + 2,
    localparam int ADDR_W = SET_W + CODE_W + ROW_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic [ROW_W-1:0]  row,
    input  logic [GRP_W-1:0]  grp,
    input  logic              sel_hi,
    input  logic              sel_lo,
    output logic [ADDR_W-1:0] addr
);
    logic [SET_W-1:0] set_idx;

    always_comb begin
        set_idx = {grp, sel_hi, sel_lo};
        addr    = {set_idx, code, row};
    end
endmodule

// File: rtl/text_dot_shifter.sv
module text_dot_shifter
    import text_dot_pkg::*;
#(
    parameter int GLYPH_W = 8,
    localparam int CNT_W  = (GLYPH_W > 1) ? $clog2(GLYPH_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GLYPH_W-1:0] glyph,
    output logic               busy,
    output logic               dot_bit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GLYPH_W - 1);

    shift_state_t       state_q, state_d;
    logic [GLYPH_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_SHIFT;                  // LOAD_GLYPH
            ST_SHIFT: if (!load && cnt_q == LAST) state_d = ST_IDLE;  // CELL_DONE (else RELOAD/stay)
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= glyph;
            cnt_q <= '0;
        end else if (state_q == ST_SHIFT) begin
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy    = (state_q == ST_SHIFT);
        dot_bit = sh_q[GLYPH_W-1];
    end

    assert_load_shows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
    assert_cell_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && cnt_q == LAST) |=> !busy);
    assert_cell_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> busy);
    assert_reload_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));
endmodule

// File: rtl/text_dot_colour.sv
module text_dot_colour #(
    parameter int COLOR_W = 3
) (
    input  logic               valid,
    input  logic               dot_bit,
    input  logic [COLOR_W-1:0] fg,
    input  logic [COLOR_W-1:0] bg,
    output logic [COLOR_W-1:0] rgb
);
    always_comb begin
        if (!valid)       rgb = '0;
        else if (dot_bit) rgb = fg;
        else              rgb = bg;
    end
endmodule

// File: rtl/text_dot_gen.sv
module text_dot_gen
    import text_dot_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int ROW_W   = 3,
    parameter int GRP_W   = 2,
    parameter int GLYPH_W = 8,
    parameter int COLOR_W = 3,
    localparam int ADDR_W = GRP_W + 2 + CODE_W + ROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [ATTR_W-1:0]  attr_i,
    input  logic [ROW_W-1:0]   row_i,
    input  logic [GRP_W-1:0]   group_i,
    output logic [ADDR_W-1:0]  rom_addr_o,
    input  logic [GLYPH_W-1:0] rom_data_i,
    output logic               dot_valid_o,
    output logic [COLOR_W-1:0] dot_rgb_o
);
    logic              load_q;
    logic [ATTR_W-1:0] attr_wait_q;
    logic [ATTR_W-1:0] attr_show_q;
    logic              dot_bit;
    logic              busy;

    text_dot_addr #(.CODE_W(CODE_W), .ROW_W(ROW_W), .GRP_W(GRP_W)) u_addr (
        .code   (code_i),
        .row    (row_i),
        .grp    (group_i),
        .sel_hi (attr_i[ATTR_SEL_HI]),
        .sel_lo (attr_i[ATTR_SEL_LO]),
        .addr   (rom_addr_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q      <= 1'b0;
            attr_wait_q <= '0;
            attr_show_q <= '0;
        end else begin
            load_q <= fetch_i;
            if (fetch_i) attr_wait_q <= attr_i;
            if (load_q)  attr_show_q <= attr_wait_q;
        end
    end

    text_dot_shifter #(.GLYPH_W(GLYPH_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_q),
        .glyph   (rom_data_i),
        .busy    (busy),
        .dot_bit (dot_bit)
    );

    text_dot_colour #(.COLOR_W(COLOR_W)) u_colour (
        .valid   (busy),
        .dot_bit (dot_bit),
        .fg      (attr_show_q[ATTR_FG_LSB +: COLOR_W]),
        .bg      (attr_show_q[ATTR_BG_LSB +: COLOR_W]),
        .rgb     (dot_rgb_o)
    );

    assign dot_valid_o = busy;

    assert_idle_black_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_valid_o |-> (dot_rgb_o == '0));
    assert_first_dot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_i |=> ##1 dot_valid_o);
    assert_attr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_i |=> $stable(attr_wait_q));
    assert_colour_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dot_valid_o |-> (dot_rgb_o == attr_show_q[ATTR_FG_LSB +: COLOR_W]
                      || dot_rgb_o == attr_show_q[ATTR_BG_LSB +: COLOR_W]));
endmodule

// File: tb/text_dot_gen_tb.sv
module text_dot_gen_tb;
    localparam int CYC = 300;
    localparam int EXT = CYC + 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i = 1'b0;
    logic [7:0]  code_i = '0;
    logic [7:0]  attr_i = '0;
    logic [2:0]  row_i = '0;
    logic [1:0]  group_i = '0;
    logic [14:0] rom_addr_o;
    logic [7:0]  rom_data_i;
    logic        dot_valid_o;
    logic [2:0]  dot_rgb_o;

    int nvec = 0;
    int nfail = 0;

    logic       sch    [CYC];
    logic [7:0] s_code [CYC];
    logic [7:0] s_attr [CYC];
    logic [2:0] s_row  [CYC];
    logic [1:0] s_grp  [CYC];
    logic       e_val  [EXT];
    logic [2:0] e_rgb  [EXT];

    always #5 clk = ~clk;

    text_dot_gen u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .code_i(code_i),
        .attr_i(attr_i), .row_i(row_i), .group_i(group_i),
        .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
        .dot_valid_o(dot_valid_o), .dot_rgb_o(dot_rgb_o)
    );

    function automatic logic [7:0] rom_f(input logic [14:0] a);
        return (a[7:0] ^ a[14:7]) + 8'h5A + {a[2:0], 5'd0};
    endfunction

    always_ff @(posedge clk) rom_data_i <= rom_f(rom_addr_o);

    function automatic logic [14:0] exp_addr(input logic [1:0] g, input logic [7:0] at,
                                             input logic [7:0] cd, input logic [2:0] rw);
        return {g, at[7], at[3], cd, rw};
    endfunction

    task automatic build(input int mode);
        for (int c = 0; c < CYC; c++) begin
            sch[c]    = 1'b0;
            s_code[c] = 8'($urandom);
            s_attr[c] = 8'($urandom);
            s_row[c]  = 3'($urandom);
            s_grp[c]  = 2'($urandom);
        end
        for (int f = 0; f < CYC - 12; ) begin
            sch[f] = 1'b1;
            if (mode == 3) s_attr[f] = 8'h70;
            if (mode == 4) begin
                s_attr[f] = ((f / 8) % 2 == 0) ? 8'h08 : 8'h88;
                s_grp[f]  = 2'((f / 16) % 4);
            end
            case (mode)
                1:       f += 8 + int'($urandom % 7);
                2:       f += 3 + int'($urandom % 5);
                default: f += 8;
            endcase
        end
        for (int c = 0; c < EXT; c++) begin
            e_val[c] = 1'b0;
            e_rgb[c] = 3'b000;
        end
        for (int f = 0; f < CYC; f++) begin
            if (sch[f]) begin
                logic [7:0] g;
                g = rom_f(exp_addr(s_grp[f], s_attr[f], s_code[f], s_row[f]));
                for (int k = 0; k < 8; k++) begin
                    e_val[f+2+k] = 1'b1;
                    e_rgb[f+2+k] = g[7-k] ? s_attr[f][6:4] : s_attr[f][2:0];
                end
            end
        end
    endtask

    task automatic run(input string tag);
        for (int c = 0; c < EXT; c++) begin
            @(negedge clk);
            nvec++;
            if (dot_valid_o !== e_val[c] || dot_rgb_o !== e_rgb[c]) begin
                nfail++;
                $display("FAIL %s cycle %0d: valid/rgb actual %b/%b expected %b/%b",
                         tag, c, dot_valid_o, dot_rgb_o, e_val[c], e_rgb[c]);
            end
            if (c < CYC) begin
                fetch_i = sch[c]; code_i = s_code[c]; attr_i = s_attr[c];
                row_i = s_row[c]; group_i = s_grp[c];
            end else begin
                fetch_i = 1'b0; attr_i = 8'($urandom); code_i = 8'($urandom);
            end
            #1;
            if (fetch_i) begin
                logic [14:0] ea;
                ea = exp_addr(group_i, attr_i, code_i, row_i);
                nvec++;
                if (rom_addr_o !== ea) begin
                    nfail++;
                    $display("FAIL R1 cycle %0d: addr actual %h expected %h", c, rom_addr_o, ea);
                end
            end
        end
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nvec++;
        if (dot_valid_o !== 1'b0 || dot_rgb_o !== 3'b000) begin
            nfail++;
            $display("FAIL R2 reset: actual %b/%b expected 0/000", dot_valid_o, dot_rgb_o);
        end
        // directed slot-1 address: group 00, only attr bit 3 set
        fetch_i = 1'b1; group_i = 2'b00; attr_i = 8'h08; code_i = 8'h00; row_i = 3'd0;
        #1;
        nvec++;
        if (rom_addr_o !== 15'h0800) begin
            nfail++;
            $display("FAIL R1 slot1: actual %h expected 0800", rom_addr_o);
        end
        @(negedge clk); fetch_i = 1'b0;
        repeat (12) @(negedge clk);
        build(0); run("R3 R4 R5 R6 continuous");
        build(1); run("R2 R5 R7 gapped");
        build(2); run("R9 early-fetch");
        build(3); run("R8 attr70");
        build(4); run("R1 R4 set-select");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule